// File: doc/BRIEF.md
# Dual-Issue Pairing Check Unit

This unit sits at the issue stage of an in-order core with two execution ports. Each cycle it looks at the two oldest micro-ops of the thread selected for issue. It decides whether both can leave together or only the older one. When both leave, it also picks which port each one uses. The two ports can do different things. Port 0 is the only port for memory access, shifts and shuffles, multiply, divide and x87 stack work. Port 1 is the only port for branches and floating-point or vector adds. Simple ALU work and register moves can use either port.

The decision is registered, so it appears one cycle after the candidates are presented. When pairing fails, only the older micro-op issues. The surrounding issue logic then moves the younger one into slot 0 for the next cycle. Two x87 stack micro-ops side by side also raise a one-cycle bubble flag. Scoreboarding against older in-flight work is done elsewhere.

Top module: `pair_issue_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `issueCnt`, `slot0Port`, `slot1Port` and `x87Bubble` are all 0, whatever the inputs are.
- R2: The outputs reflect the inputs of the previous clock cycle. `issueCnt` is 0 when slot 0 is invalid. It is 1 when slot 0 is valid and slot 1 is invalid. It is 2 only when every pairing rule below is met.
- R3: The class code gives the usable ports. 0 ALU works on either port. 1 memory, 2 shift/shuffle, 3 multiply, 4 divide and 7 x87 work on port 0 only. 5 branch and 6 FP/vector add work on port 1 only. A pair whose classes cannot be placed on two different capable ports issues 1.
- R4: A pair issues only when it is consecutive. That means `u1Pc == u0Pc + u0Len`, or slot 0 is a branch (class 5) whose `u0Target` equals `u1Pc`.
- R5: A pair issues 1 when any valid source of slot 1 equals the valid destination of slot 0. Sources whose valid bit is 0 are ignored.
- R6: A pair issues 1 when slot 0 writes flags and slot 1 reads them. The exception is when slot 1 is a conditional jump (`u1CondJmp`); then the pair may still issue 2.
- R7: A pair issues 1 when both valid destinations name the same register. A destination whose valid bit is 0 does not conflict.
- R8: When 2 issue, the two ports differ. Slot 0 takes port 0 (`slot0Port=0`, `slot1Port=1`) unless that placement is not legal; then the swapped placement is used.
- R9: A micro-op marked `DualPort` in either slot never pairs.
- R10: When both slots are valid x87 micro-ops (class 7), `issueCnt` is 1 and `x87Bubble` is 1. Otherwise `x87Bubble` is 0.
- R11: When only slot 0 issues, `slot0Port` is 0 if its class can use port 0, else 1, and `slot1Port` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| u0Vld | input | 1 | Slot 0 (older) holds a micro-op |
| u0Pc | input | ADDR_W | Slot 0 address |
| u0Len | input | LEN_W | Slot 0 length in bytes |
| u0Cls | input | 3 | Slot 0 class code (see R3) |
| u0Dst | input | REG_W | Slot 0 destination register |
| u0DstVld | input | 1 | Slot 0 writes `u0Dst` |
| u0FlagWr | input | 1 | Slot 0 writes flags |
| u0DualPort | input | 1 | Slot 0 needs units on both ports |
| u0Target | input | ADDR_W | Slot 0 branch target |
| u1Vld | input | 1 | Slot 1 (younger) holds a micro-op |
| u1Pc | input | ADDR_W | Slot 1 address |
| u1Cls | input | 3 | Slot 1 class code |
| u1Src | input | NSRC*REG_W | Slot 1 source registers, source i at bits i*REG_W |
| u1SrcVld | input | NSRC | Slot 1 source valid bits |
| u1Dst | input | REG_W | Slot 1 destination register |
| u1DstVld | input | 1 | Slot 1 writes `u1Dst` |
| u1FlagRd | input | 1 | Slot 1 reads flags |
| u1DualPort | input | 1 | Slot 1 needs units on both ports |
| u1CondJmp | input | 1 | Slot 1 is a conditional jump |
| issueCnt | output | 2 | Micro-ops issued: 0, 1 or 2 |
| slot0Port | output | 1 | Port given to slot 0 |
| slot1Port | output | 1 | Port given to slot 1 (0 when not issued) |
| x87Bubble | output | 1 | Insert one extra stall cycle |

## Verification
The hardest cases are the ones where a blocking rule is met but an exemption should let the pair through. Examples are a flag dependency that feeds a conditional jump, a taken branch whose target is the younger micro-op, and a source match whose valid bit is clear. Random stimulus rarely builds these by chance. The bench therefore draws register numbers from a very small pool, picks `u1Pc` from a short list that includes the fall-through address and the branch target, and adds directed vectors for each exemption. A swapped port placement needs a flexible older op next to a port-0-only younger op, so directed vectors cover that too.

// File: rtl/pair_pkg.sv
package pair_pkg;

  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_MEM    = 3'd1,
    CLS_SHIFT  = 3'd2,
    CLS_MUL    = 3'd3,
    CLS_DIV    = 3'd4,
    CLS_BRANCH = 3'd5,
    CLS_FPADD  = 3'd6,
    CLS_X87    = 3'd7
  } uopCls_e;

  // Strobes from the hazard datapath to the issue control
  typedef struct packed {
    logic       vld0;
    logic       vld1;
    logic       adjacent;
    logic       regRaw;
    logic       flagRaw;
    logic       waw;
    logic       dual;
    logic       bothX87;
    logic [1:0] cap0;   // bit0: port 0 usable, bit1: port 1 usable
    logic [1:0] cap1;
  } pairStrobe_t;

  function automatic logic [1:0] portCaps(input logic [2:0] cls);
    logic [1:0] caps;
    case (uopCls_e'(cls))
      CLS_ALU:               caps = 2'b11;
      CLS_BRANCH, CLS_FPADD: caps = 2'b10;
      default:               caps = 2'b01;
    endcase
    return caps;
  endfunction

endpackage

// File: rtl/pair_hazard_dp.sv
module pair_hazard_dp
  import pair_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4,
  parameter int NSRC   = 2
) (
  input  logic                   u0Vld,
  input  logic [ADDR_W-1:0]      u0Pc,
  input  logic [LEN_W-1:0]       u0Len,
  input  logic [2:0]             u0Cls,
  input  logic [REG_W-1:0]       u0Dst,
  input  logic                   u0DstVld,
  input  logic                   u0FlagWr,
  input  logic                   u0DualPort,
  input  logic [ADDR_W-1:0]      u0Target,
  input  logic                   u1Vld,
  input  logic [ADDR_W-1:0]      u1Pc,
  input  logic [2:0]             u1Cls,
  input  logic [NSRC*REG_W-1:0]  u1Src,
  input  logic [NSRC-1:0]        u1SrcVld,
  input  logic [REG_W-1:0]       u1Dst,
  input  logic                   u1DstVld,
  input  logic                   u1FlagRd,
  input  logic                   u1DualPort,
  input  logic                   u1CondJmp,
  output pairStrobe_t            strobe
);

  logic [NSRC-1:0]   srcHit;
  logic [ADDR_W-1:0] fallThru;

  for (genvar i = 0; i < NSRC; i++) begin : g_srcCmp
    assign srcHit[i] = u1SrcVld[i] && u0DstVld &&
                       (u1Src[i*REG_W +: REG_W] == u0Dst);
  end

  assign fallThru = u0Pc + ADDR_W'(u0Len);

  always_comb begin
    strobe.vld0     = u0Vld;
    strobe.vld1     = u1Vld;
    strobe.adjacent = (u1Pc == fallThru) ||
                      ((uopCls_e'(u0Cls) == CLS_BRANCH) && (u0Target == u1Pc));
    strobe.regRaw   = |srcHit;
    strobe.flagRaw  = u0FlagWr && u1FlagRd && !u1CondJmp;
    strobe.waw      = u0DstVld && u1DstVld && (u0Dst == u1Dst);
    strobe.dual     = u0DualPort || u1DualPort;
    strobe.bothX87  = (uopCls_e'(u0Cls) == CLS_X87) && (uopCls_e'(u1Cls) == CLS_X87);
    strobe.cap0     = portCaps(u0Cls);
    strobe.cap1     = portCaps(u1Cls);
  end

endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
  import pair_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pairStrobe_t strobe,
  output logic [1:0]  issueCnt,
  output logic        slot0Port,
  output logic        slot1Port,
  output logic        x87Bubble
);

  logic       keepOrder;   // slot 0 on port 0, slot 1 on port 1
  logic       swapOrder;   // slot 0 on port 1, slot 1 on port 0
  logic       canPair;
  logic [1:0] nextCnt;
  logic       nextP0;
  logic       nextP1;
  logic       nextBub;

  always_comb begin
    keepOrder = strobe.cap0[0] && strobe.cap1[1];
    swapOrder = strobe.cap0[1] && strobe.cap1[0];
    canPair   = strobe.vld0 && strobe.vld1 && strobe.adjacent &&
                !strobe.regRaw && !strobe.flagRaw && !strobe.waw &&
                !strobe.dual && !strobe.bothX87 && (keepOrder || swapOrder);
    nextCnt = 2'd0;
    nextP0  = 1'b0;
    nextP1  = 1'b0;
    nextBub = 1'b0;
    if (strobe.vld0) begin
      if (canPair) begin
        nextCnt = 2'd2;
        nextP0  = !keepOrder;
        nextP1  = keepOrder;
      end else begin
        nextCnt = 2'd1;
        nextP0  = !strobe.cap0[0];
      end
      nextBub = strobe.vld1 && strobe.bothX87;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueCnt  <= 2'd0;
      slot0Port <= 1'b0;
      slot1Port <= 1'b0;
      x87Bubble <= 1'b0;
    end else begin
      issueCnt  <= nextCnt;
      slot0Port <= nextP0;
      slot1Port <= nextP1;
      x87Bubble <= nextBub;
    end
  end

endmodule

// File: rtl/pair_issue_top.sv
module pair_issue_top
  import pair_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4,
  parameter int NSRC   = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   u0Vld,
  input  logic [ADDR_W-1:0]      u0Pc,
  input  logic [LEN_W-1:0]       u0Len,
  input  logic [2:0]             u0Cls,
  input  logic [REG_W-1:0]       u0Dst,
  input  logic                   u0DstVld,
  input  logic                   u0FlagWr,
  input  logic                   u0DualPort,
  input  logic [ADDR_W-1:0]      u0Target,
  input  logic                   u1Vld,
  input  logic [ADDR_W-1:0]      u1Pc,
  input  logic [2:0]             u1Cls,
  input  logic [NSRC*REG_W-1:0]  u1Src,
  input  logic [NSRC-1:0]        u1SrcVld,
  input  logic [REG_W-1:0]       u1Dst,
  input  logic                   u1DstVld,
  input  logic                   u1FlagRd,
  input  logic                   u1DualPort,
  input  logic                   u1CondJmp,
  output logic [1:0]             issueCnt,
  output logic                   slot0Port,
  output logic                   slot1Port,
  output logic                   x87Bubble
);

  pairStrobe_t strobe;

  pair_hazard_dp #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NSRC(NSRC)
  ) u_dp (
    .u0Vld(u0Vld), .u0Pc(u0Pc), .u0Len(u0Len), .u0Cls(u0Cls),
    .u0Dst(u0Dst), .u0DstVld(u0DstVld), .u0FlagWr(u0FlagWr),
    .u0DualPort(u0DualPort), .u0Target(u0Target),
    .u1Vld(u1Vld), .u1Pc(u1Pc), .u1Cls(u1Cls), .u1Src(u1Src),
    .u1SrcVld(u1SrcVld), .u1Dst(u1Dst), .u1DstVld(u1DstVld),
    .u1FlagRd(u1FlagRd), .u1DualPort(u1DualPort), .u1CondJmp(u1CondJmp),
    .strobe(strobe)
  );

  pair_issue_ctl u_ctl (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issueCnt(issueCnt), .slot0Port(slot0Port),
    .slot1Port(slot1Port), .x87Bubble(x87Bubble)
  );

endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             u0Vld,
  input logic             u1Vld,
  input logic [2:0]       u0Cls,
  input logic [2:0]       u1Cls,
  input logic             u0DualPort,
  input logic             u1DualPort,
  input logic [REG_W-1:0] u0Dst,
  input logic [REG_W-1:0] u1Dst,
  input logic             u0DstVld,
  input logic             u1DstVld,
  input logic [1:0]       issueCnt,
  input logic             slot0Port,
  input logic             slot1Port,
  input logic             x87Bubble
);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    issueCnt != 2'd3);

  p_empty_slot0_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(!u0Vld) |-> issueCnt == 2'd0);

  p_lone_slot0_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(u0Vld && !u1Vld) |-> issueCnt == 2'd1);

  p_waw_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(u0DstVld && u1DstVld && (u0Dst == u1Dst)) |-> issueCnt != 2'd2);

  p_ports_differ_r8: assert property (@(posedge clk) disable iff (!rstN)
    issueCnt == 2'd2 |-> slot0Port != slot1Port);

  p_dual_never_pairs_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(u0DualPort || u1DualPort) |-> issueCnt != 2'd2);

  p_x87_pair_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(u0Vld && u1Vld && u0Cls == 3'd7 && u1Cls == 3'd7)
      |-> x87Bubble && issueCnt == 2'd1);

  p_bubble_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    x87Bubble |-> issueCnt == 2'd1);

  p_single_slot1_r11: assert property (@(posedge clk) disable iff (!rstN)
    issueCnt != 2'd2 |-> !slot1Port);

endmodule

bind pair_issue_top pair_issue_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_pair_issue_top.sv
module tb_pair_issue_top;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W  = 5;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 4;
  localparam int NSRC   = 2;

  typedef struct {
    bit        v0, v1;
    int        pc0, len0, cls0, dst0, tgt0;
    bit        dv0, fw0, dp0;
    int        pc1, cls1, dst1;
    int        src[NSRC];
    bit        sv[NSRC];
    bit        dv1, fr1, dp1, cj1;
  } vec_t;

  typedef struct { int cnt; int p0; int p1; int bub; } res_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic u0Vld, u0DstVld, u0FlagWr, u0DualPort;
  logic [ADDR_W-1:0] u0Pc, u0Target, u1Pc;
  logic [LEN_W-1:0] u0Len;
  logic [2:0] u0Cls, u1Cls;
  logic [REG_W-1:0] u0Dst, u1Dst;
  logic u1Vld, u1DstVld, u1FlagRd, u1DualPort, u1CondJmp;
  logic [NSRC*REG_W-1:0] u1Src;
  logic [NSRC-1:0] u1SrcVld;
  logic [1:0] issueCnt;
  logic slot0Port, slot1Port, x87Bubble;

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;
  res_t expRes;
  string expTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_issue_top #(.REG_W(REG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NSRC(NSRC)) dut (.*);

  // class -> can use port p (R3)
  function automatic bit canUse(int cls, int p);
    if (cls == 0) return 1;
    if (cls == 5 || cls == 6) return p == 1;
    return p == 0;
  endfunction

  function automatic res_t model(vec_t v, bit inReset);
    res_t r = '{0, 0, 0, 0};
    bit ok;
    int nextAddr;
    if (inReset || !v.v0) return r;
    r.cnt = 1;
    r.p0 = canUse(v.cls0, 0) ? 0 : 1;                        // R11
    if (v.v1 && v.cls0 == 7 && v.cls1 == 7) begin r.bub = 1; return r; end  // R10
    if (!v.v1 || v.dp0 || v.dp1) return r;                   // R9
    nextAddr = (v.pc0 + v.len0) % (1 << ADDR_W);
    if (!(v.pc1 == nextAddr || (v.cls0 == 5 && v.tgt0 == v.pc1))) return r;  // R4
    for (int i = 0; i < NSRC; i++)
      if (v.sv[i] && v.dv0 && v.src[i] == v.dst0) return r;  // R5
    if (v.fw0 && v.fr1 && !v.cj1) return r;                  // R6
    if (v.dv0 && v.dv1 && v.dst0 == v.dst1) return r;        // R7
    ok = 0;
    for (int a = 0; a < 2 && !ok; a++)                       // R8: port 0 first
      if (canUse(v.cls0, a) && canUse(v.cls1, 1 - a)) begin
        ok = 1; r.cnt = 2; r.p0 = a; r.p1 = 1 - a;
      end
    return r;
  endfunction

  task automatic drivePins(vec_t v);
    u0Vld = v.v0; u0Pc = ADDR_W'(v.pc0); u0Len = LEN_W'(v.len0);
    u0Cls = 3'(v.cls0); u0Dst = REG_W'(v.dst0); u0DstVld = v.dv0;
    u0FlagWr = v.fw0; u0DualPort = v.dp0; u0Target = ADDR_W'(v.tgt0);
    u1Vld = v.v1; u1Pc = ADDR_W'(v.pc1); u1Cls = 3'(v.cls1);
    u1Dst = REG_W'(v.dst1); u1DstVld = v.dv1; u1FlagRd = v.fr1;
    u1DualPort = v.dp1; u1CondJmp = v.cj1;
    for (int i = 0; i < NSRC; i++) begin
      u1Src[i*REG_W +: REG_W] = REG_W'(v.src[i]);
      u1SrcVld[i] = v.sv[i];
    end
  endtask

  task automatic compareOut();
    applied++;
    if (int'(issueCnt) != expRes.cnt || int'(slot0Port) != expRes.p0 ||
        int'(slot1Port) != expRes.p1 || int'(x87Bubble) != expRes.bub) begin
      miscompares++;
      $display("FAIL %s: actual cnt=%0d p0=%0d p1=%0d bub=%0d expected cnt=%0d p0=%0d p1=%0d bub=%0d",
               expTag, issueCnt, slot0Port, slot1Port, x87Bubble,
               expRes.cnt, expRes.p0, expRes.p1, expRes.bub);
    end
  endtask

  // One clock: check previous result, then present the next vector
  task automatic step(vec_t v, bit resetNow, string tag);
    @(negedge clk);
    compareOut();
    rstN = !resetNow;
    drivePins(v);
    expRes = model(v, resetNow);
    expTag = tag;
  endtask

  function automatic vec_t base();
    vec_t v;
    v.v0 = 1; v.v1 = 1; v.pc0 = 100; v.len0 = 3; v.cls0 = 0; v.dst0 = 1;
    v.tgt0 = 500; v.dv0 = 1; v.fw0 = 0; v.dp0 = 0;
    v.pc1 = 103; v.cls1 = 0; v.dst1 = 2; v.dv1 = 1; v.fr1 = 0; v.dp1 = 0; v.cj1 = 0;
    for (int i = 0; i < NSRC; i++) begin v.src[i] = 10 + i; v.sv[i] = 1; end
    return v;
  endfunction

  initial begin
    vec_t v;
    v = base();
    drivePins(v);
    expRes = '{0, 0, 0, 0};
    expTag = "R1";
    // R1: pairable inputs held during reset leave outputs at zero
    for (int k = 0; k < 3; k++) step(v, 1, "R1");
    v = base();                                   step(v, 0, "R8 alu+alu");
    v = base(); v.cls1 = 1;                       step(v, 0, "R8 swap alu+mem");
    v = base(); v.cls0 = 1; v.cls1 = 2;           step(v, 0, "R3 mem+shift");
    v = base(); v.cls0 = 5; v.cls1 = 6;           step(v, 0, "R3 branch+fpadd");
    v = base(); v.cls0 = 3; v.cls1 = 5;           step(v, 0, "R3 mul+branch");
    v = base(); v.cls0 = 4; v.cls1 = 0;           step(v, 0, "R3 div+alu");
    v = base(); v.pc1 = 104;                      step(v, 0, "R4 gap");
    v = base(); v.cls0 = 5; v.pc1 = 500;          step(v, 0, "R4 branch target");
    v = base(); v.cls0 = 5; v.pc1 = 501;          step(v, 0, "R4 target miss");
    v = base(); v.cls0 = 0; v.pc1 = 500;          step(v, 0, "R4 nonbranch target");
    v = base(); v.src[1] = 1;                     step(v, 0, "R5 raw");
    v = base(); v.src[0] = 1; v.sv[0] = 0;        step(v, 0, "R5 src invalid");
    v = base(); v.src[0] = 1; v.dv0 = 0; v.dst1 = 1; v.dv1 = 1; step(v, 0, "R5 dst invalid");
    v = base(); v.fw0 = 1; v.fr1 = 1;             step(v, 0, "R6 flag raw");
    v = base(); v.cls0 = 3; v.fw0 = 1; v.fr1 = 1; v.cls1 = 5; v.cj1 = 1; step(v, 0, "R6 condjmp");
    v = base(); v.dst1 = 1;                       step(v, 0, "R7 waw");
    v = base(); v.dst1 = 1; v.dv1 = 0;            step(v, 0, "R7 waw invalid");
    v = base(); v.dp0 = 1;                        step(v, 0, "R9 dual slot0");
    v = base(); v.dp1 = 1;                        step(v, 0, "R9 dual slot1");
    v = base(); v.cls0 = 7; v.cls1 = 7;           step(v, 0, "R10 x87 pair");
    v = base(); v.cls0 = 7; v.cls1 = 7; v.pc1 = 9; step(v, 0, "R10 x87 nonadjacent");
    v = base(); v.cls0 = 7; v.cls1 = 0;           step(v, 0, "R10 x87+alu");
    v = base(); v.v0 = 0;                         step(v, 0, "R2 empty");
    v = base(); v.v1 = 0;                         step(v, 0, "R2 lone");
    v = base(); v.v1 = 0; v.cls0 = 6;             step(v, 0, "R11 lone fpadd");
    v = base(); v.cls0 = 6; v.cls1 = 6;           step(v, 0, "R11 port1 clash");
    v = base();                                   step(v, 1, "R1 reset again");
    v = base();                                   step(v, 0, "R1 after reset");
    for (int n = 0; n < 3000; n++) begin
      v.v0 = ($urandom_range(0, 9) != 0);
      v.v1 = ($urandom_range(0, 7) != 0);
      v.pc0 = $urandom_range(0, 65535); v.len0 = $urandom_range(1, 15);
      v.tgt0 = $urandom_range(0, 65535);
      case ($urandom_range(0, 3))
        0, 1: v.pc1 = (v.pc0 + v.len0) % 65536;
        2:    v.pc1 = v.tgt0;
        default: v.pc1 = $urandom_range(0, 65535);
      endcase
      v.cls0 = $urandom_range(0, 7); v.cls1 = $urandom_range(0, 7);
      v.dst0 = $urandom_range(0, 3); v.dst1 = $urandom_range(0, 3);
      v.dv0 = $urandom_range(0, 1); v.dv1 = $urandom_range(0, 1);
      v.fw0 = $urandom_range(0, 1); v.fr1 = $urandom_range(0, 1);
      v.cj1 = $urandom_range(0, 1);
      v.dp0 = ($urandom_range(0, 7) == 0); v.dp1 = ($urandom_range(0, 7) == 0);
      for (int i = 0; i < NSRC; i++) begin
        v.src[i] = $urandom_range(0, 5); v.sv[i] = $urandom_range(0, 1);
      end
      step(v, ($urandom_range(0, 199) == 0), "R2 random");
    end
    @(negedge clk);
    compareOut();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL R2 watchdog: actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

endmodule